// File: doc/BRIEF.md
# Page Translation Unit with Four-Set TLB

This block turns a 14-bit virtual address into a 12-bit physical address for a small paged system with 64-byte pages. Each request is first checked against a 16-entry translation buffer. The buffer is organised as four sets of four ways, and the set is chosen by the low bits of the virtual page number. When the page is found, the physical address is returned one cycle after the request. When it is not found, the block reads the page table entry for that page from an internal single-level table, which has a read latency of one cycle. If the entry is valid, the block copies it into the buffer and returns the translation. If the entry is invalid, the block reports a page fault instead.

The page table is written from outside through a preload port, one entry per cycle. A synchronous flush input invalidates every buffer entry, for example after the table has been rewritten. The block works on one translation at a time. While a miss is being resolved, new requests are dropped, so the requester waits for `done` before it issues the next one.

Top module: `vm_xlat`

## Requirements
- R1: The virtual address is split into an offset (bits 5:0) and a page number (bits 13:6). The page number is split again into a set index (its bits 1:0) and a tag (its bits 7:2). The physical address is {page frame, offset}, and the offset passes through unchanged. For example, 0x03D4 with frame 0x0D gives 0x354.
- R2: A request whose page number is held in a valid way of its set completes one cycle after the request is sampled. It returns `done`=1 and `tlb_hit`=1 together with the physical address.
- R3: A request that misses completes three cycles after it is sampled, with `tlb_hit`=0. The physical address is built from the frame in the page table entry. For example, 0x0020 with entry 0x00 holding frame 0x28 gives 0xA20.
- R4: A miss that finds a valid page table entry installs that page in the buffer, so a later request to the same page hits.
- R5: A miss that finds an invalid entry completes after three cycles with `fault`=1, `tlb_hit`=0 and `paddr`=0. Nothing is installed, so a repeat request faults again after three cycles.
- R6: A refill writes to the lowest-numbered invalid way of the set. When all four ways are valid, it writes to the way named by that set's rotating pointer. The pointer starts at way 0 and advances by one only when it is used.
- R7: A refill changes only the set that the page number selects. Pages held in other sets still hit.
- R8: A cycle with `flush`=1 invalidates all buffer entries, so the next request to any page misses.
- R9: A request presented while a miss is being resolved is ignored and produces no completion.
- R10: `done` is high for exactly one cycle per translation. When `done` is low, `paddr`, `tlb_hit` and `fault` are all 0.
- R11: After reset the buffer is empty, every page table entry is invalid and all outputs are 0.
- R12: A preload write stores valid and frame at the given page number. A table read made on a later cycle returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address to translate |
| pt_wr_en | input | 1 | Page table preload write strobe |
| pt_wr_idx | input | 8 | Page number of the entry to write |
| pt_wr_valid | input | 1 | Valid bit to store |
| pt_wr_ppn | input | 6 | Page frame to store |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 12 | Physical address, qualified by done |
| tlb_hit | output | 1 | Translation was served from the buffer |
| fault | output | 1 | Page table entry was invalid |

## Verification
A buffer hit is due one cycle after the rising edge that samples the request. A miss, whether it ends in a refill or in a fault, is due three cycles after that edge. The driver computes this due cycle from the expected hit or miss outcome and stores it in the scoreboard together with the expected address and flags. The monitor checks on every falling edge: it requires each completion to arrive exactly in its stored cycle, flags any completion that was not expected, and requires all outputs to be zero on cycles without `done`.

// File: rtl/vm_xlat_pkg.sv
// Package: shared widths, the page table entry type and the controller states.
// Assumes WAYS and SETS are powers of two.
package vm_xlat_pkg;
    parameter int VA_W  = 14;
    parameter int PA_W  = 12;
    parameter int OFF_W = 6;
    parameter int SETS  = 4;
    parameter int WAYS  = 4;

    localparam int VPN_W    = VA_W - OFF_W;
    localparam int PPN_W    = PA_W - OFF_W;
    localparam int SET_W    = $clog2(SETS);
    localparam int TAG_W    = VPN_W - SET_W;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int PT_DEPTH = 1 << VPN_W;

    typedef struct packed {
        logic             valid;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_FILL = 2'd2
    } xlat_state_e;
endpackage

// File: rtl/vm_xlat_ptab.sv
// Single-level page table: one entry per virtual page, written through a
// preload port. The read port is synchronous with one cycle of latency.
// Assumes a read and a write in the same cycle return the old contents.
module vm_xlat_ptab
    import vm_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  pte_t             wr_pte,
    input  logic             rd_en,
    input  logic [VPN_W-1:0] rd_idx,
    output pte_t             rd_pte
);
    logic             vld_mem [PT_DEPTH];
    logic [PPN_W-1:0] ppn_mem [PT_DEPTH];

    // Valid bits: cleared by reset, set or cleared by preload writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_DEPTH; i++) vld_mem[i] <= 1'b0;
        end else if (wr_en) begin
            vld_mem[wr_idx] <= wr_pte.valid;
        end
    end

    // Frame storage: written by preload, needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en) ppn_mem[wr_idx] <= wr_pte.ppn;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pte <= '0;
        end else if (rd_en) begin
            rd_pte.valid <= vld_mem[rd_idx];
            rd_pte.ppn   <= ppn_mem[rd_idx];
        end
    end
endmodule

// File: rtl/vm_xlat_tlb.sv
// Set-associative translation buffer. Lookup is combinational. A refill
// writes the lowest invalid way of its set, or the way named by the set's
// rotating pointer when the set is full. Flush takes priority over refill.
// Assumes the controller refills only pages that missed.
module vm_xlat_tlb
    import vm_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn
);
    logic             ent_vld [SETS][WAYS];
    logic [TAG_W-1:0] ent_tag [SETS][WAYS];
    logic [PPN_W-1:0] ent_ppn [SETS][WAYS];
    logic [WAY_W-1:0] rr_ptr  [SETS];

    logic [SET_W-1:0] lk_set, fill_set;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    logic [WAYS-1:0]  way_match;
    logic [WAY_W-1:0] victim;
    logic             use_rr;

    assign lk_set   = lk_vpn[SET_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:SET_W];
    assign fill_set = fill_vpn[SET_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:SET_W];

    // Per-way tag comparators for the indexed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = ent_vld[lk_set][w] && (ent_tag[lk_set][w] == lk_tag);
    end

    // Hit flag and frame select.
    always_comb begin
        lk_hit = |way_match;
        lk_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) lk_ppn = ent_ppn[lk_set][w];
        end
    end

    // Victim choice: lowest invalid way, else the rotating pointer.
    always_comb begin
        victim = rr_ptr[fill_set];
        use_rr = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!ent_vld[fill_set][w]) begin
                victim = WAY_W'(w);
                use_rr = 1'b0;
            end
        end
    end

    // Valid bits and rotating pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr_ptr[s] <= '0;
                for (int w = 0; w < WAYS; w++) ent_vld[s][w] <= 1'b0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) ent_vld[s][w] <= 1'b0;
        end else if (fill_en) begin
            ent_vld[fill_set][victim] <= 1'b1;
            if (use_rr) rr_ptr[fill_set] <= rr_ptr[fill_set] + 1'b1;
        end
    end

    // Tag and frame storage of the victim way.
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            ent_tag[fill_set][victim] <= fill_tag;
            ent_ppn[fill_set][victim] <= fill_ppn;
        end
    end

    logic [SETS*WAYS-1:0] vld_flat;
    logic                 fill_dup;

    // Observation signals for the checks below.
    always_comb begin
        fill_dup = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) vld_flat[s*WAYS+w] = ent_vld[s][w];
        for (int w = 0; w < WAYS; w++)
            if (ent_vld[fill_set][w] && ent_tag[fill_set][w] == fill_tag) fill_dup = 1'b1;
    end

    // R6
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !fill_dup);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(vld_flat) == 0));
endmodule

// File: rtl/vm_xlat_ctrl.sv
// Translation sequencer. A hit completes on the edge that samples the request.
// A miss reads the page table, waits one cycle for the data, then either
// refills the buffer and completes, or completes with a fault. Requests are
// dropped outside the idle state. Outputs are registered and are zero when
// done is low.
module vm_xlat_ctrl
    import vm_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             rd_en,
    output logic [VPN_W-1:0] rd_idx,
    input  pte_t             rd_pte,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PPN_W-1:0] fill_ppn,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic             tlb_hit,
    output logic             fault
);
    xlat_state_e     state;
    logic [VA_W-1:0] va_q;

    assign lk_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign rd_en    = (state == ST_READ);
    assign rd_idx   = va_q[VA_W-1:OFF_W];
    assign fill_en  = (state == ST_FILL) && rd_pte.valid;
    assign fill_vpn = va_q[VA_W-1:OFF_W];
    assign fill_ppn = rd_pte.ppn;

    // Sequencer state and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            done    <= 1'b0;
            paddr   <= '0;
            tlb_hit <= 1'b0;
            fault   <= 1'b0;
        end else begin
            done    <= 1'b0;
            paddr   <= '0;
            tlb_hit <= 1'b0;
            fault   <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    if (lk_hit && !flush) begin
                        done    <= 1'b1;
                        tlb_hit <= 1'b1;
                        paddr   <= {lk_ppn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        va_q  <= req_vaddr;
                        state <= ST_READ;
                    end
                end
                ST_READ: state <= ST_FILL;
                ST_FILL: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                    if (rd_pte.valid) paddr <= {rd_pte.ppn, va_q[OFF_W-1:0]};
                    else              fault <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_hit |-> (done && !fault));

    // R5
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !tlb_hit && paddr == '0));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tlb_hit) |-> (paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !done);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (paddr == '0 && !tlb_hit && !fault));
endmodule

// File: rtl/vm_xlat.sv
// Top level of the page translation unit: controller, translation buffer and
// page table. Assumes the requester waits for done before its next request.
module vm_xlat
    import vm_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             pt_wr_en,
    input  logic [VPN_W-1:0] pt_wr_idx,
    input  logic             pt_wr_valid,
    input  logic [PPN_W-1:0] pt_wr_ppn,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic             tlb_hit,
    output logic             fault
);
    logic [VPN_W-1:0] lk_vpn, rd_idx, fill_vpn;
    logic [PPN_W-1:0] lk_ppn, fill_ppn;
    logic             lk_hit, rd_en, fill_en;
    pte_t             rd_pte, wr_pte;

    assign wr_pte = '{valid: pt_wr_valid, ppn: pt_wr_ppn};

    vm_xlat_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_pte(rd_pte),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .done(done), .paddr(paddr), .tlb_hit(tlb_hit), .fault(fault)
    );

    vm_xlat_tlb u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
    );

    vm_xlat_ptab u_ptab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pt_wr_en), .wr_idx(pt_wr_idx), .wr_pte(wr_pte),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_pte(rd_pte)
    );
endmodule

// File: tb/vm_xlat_bench.sv
// Scoreboard bench: the driver queues expected results with their due cycle,
// and a monitor on the falling edge pops and compares them.
module vm_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        pt_wr_en = 1'b0;
    logic [7:0]  pt_wr_idx = '0;
    logic        pt_wr_valid = 1'b0;
    logic [5:0]  pt_wr_ppn = '0;
    logic        done, tlb_hit, fault;
    logic [11:0] paddr;

    typedef struct {
        logic [11:0] pa;
        logic        hit;
        logic        flt;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    int   dones = 0;
    int   idle_bad = 0;
    bit   mon_on = 1'b0;
    bit   reported = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vm_xlat u_vm_xlat (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .pt_wr_en(pt_wr_en), .pt_wr_idx(pt_wr_idx),
        .pt_wr_valid(pt_wr_valid), .pt_wr_ppn(pt_wr_ppn),
        .done(done), .paddr(paddr), .tlb_hit(tlb_hit), .fault(fault)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: compare each completion against the scoreboard head.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                dones++;
                checks++;
                if (sb.size() == 0) begin
                    failures++;
                    $display("FAIL R9 unexpected done: paddr=%h hit=%0b fault=%0b expected no completion",
                             paddr, tlb_hit, fault);
                end else begin
                    cur = sb.pop_front();
                    if (paddr !== cur.pa || tlb_hit !== cur.hit || fault !== cur.flt || cyc != cur.due) begin
                        failures++;
                        $display("FAIL %s: paddr=%h hit=%0b fault=%0b cycle=%0d expected paddr=%h hit=%0b fault=%0b cycle=%0d",
                                 cur.tag, paddr, tlb_hit, fault, cyc, cur.pa, cur.hit, cur.flt, cur.due);
                    end
                end
            end else if (paddr !== 12'h000 || tlb_hit !== 1'b0 || fault !== 1'b0) begin
                idle_bad++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    task automatic pt_load(input logic [7:0] idx, input logic v, input logic [5:0] ppn);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_idx = idx; pt_wr_valid = v; pt_wr_ppn = ppn;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Driver: a hit is due one cycle after sampling, a miss three.
    task automatic xlat(input logic [13:0] va, input logic [11:0] pa,
                        input logic hit, input logic flt, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        e.pa = pa; e.hit = hit; e.flt = flt; e.tag = tag;
        e.due = cyc + (hit ? 1 : 3);
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        wait (sb.size() == 0);
    endtask

    initial begin
        int d0;
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports
        checks++;
        if (done !== 1'b0 || paddr !== 12'h000 || tlb_hit !== 1'b0 || fault !== 1'b0) begin
            failures++;
            $display("FAIL R11: done=%0b paddr=%h hit=%0b fault=%0b expected all zero",
                     done, paddr, tlb_hit, fault);
        end
        mon_on = 1'b1;

        // R12: preload the table
        pt_load(8'h00, 1'b1, 6'h28);
        pt_load(8'h0F, 1'b1, 6'h0D);
        pt_load(8'h01, 1'b0, 6'h00);
        pt_load(8'h02, 1'b1, 6'h33);
        pt_load(8'h05, 1'b1, 6'h16);
        pt_load(8'h04, 1'b1, 6'h11);
        pt_load(8'h08, 1'b1, 6'h12);
        pt_load(8'h0C, 1'b1, 6'h13);
        pt_load(8'h10, 1'b1, 6'h14);

        xlat(14'h0020, 12'hA20, 1'b0, 1'b0, "R3 miss 0x0020");
        xlat(14'h003F, 12'hA3F, 1'b1, 1'b0, "R4 refill then hit 0x003F");
        xlat(14'h03D4, 12'h354, 1'b0, 1'b0, "R1 miss 0x03D4");
        xlat(14'h03D4, 12'h354, 1'b1, 1'b0, "R2 hit 0x03D4");
        xlat(14'h0040, 12'h000, 1'b0, 1'b1, "R5 fault page 0x01");
        xlat(14'h0055, 12'h000, 1'b0, 1'b1, "R5 fault repeats, no refill");
        xlat(14'h0140, 12'h580, 1'b0, 1'b0, "R3 miss set 1");

        // R6: fill set 0, then rotate
        xlat(14'h0100, 12'h440, 1'b0, 1'b0, "R6 fill way 1");
        xlat(14'h0200, 12'h480, 1'b0, 1'b0, "R6 fill way 2");
        xlat(14'h0300, 12'h4C0, 1'b0, 1'b0, "R6 fill way 3");
        xlat(14'h0400, 12'h500, 1'b0, 1'b0, "R6 full set replaces way 0");
        xlat(14'h0100, 12'h440, 1'b1, 1'b0, "R6 way 1 kept");
        xlat(14'h0000, 12'hA00, 1'b0, 1'b0, "R6 evicted page misses");
        xlat(14'h0100, 12'h440, 1'b0, 1'b0, "R6 pointer moved to way 1");
        xlat(14'h0300, 12'h4C0, 1'b1, 1'b0, "R6 way 3 kept");
        xlat(14'h0140, 12'h580, 1'b1, 1'b0, "R7 other set untouched");
        xlat(14'h03D4, 12'h354, 1'b1, 1'b0, "R7 set 3 untouched");

        // R9: requests while a miss is in flight are dropped
        d0 = dones;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 14'h0080;
        e.pa = 12'hCC0; e.hit = 1'b0; e.flt = 1'b0; e.tag = "R9 busy miss";
        e.due = cyc + 3;
        sb.push_back(e);
        @(negedge clk);
        req_vaddr = 14'h0C80;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        checks++;
        if (dones - d0 != 1 || sb.size() != 0) begin
            failures++;
            $display("FAIL R9: completions=%0d pending=%0d expected 1 and 0", dones - d0, sb.size());
        end

        // R8: flush empties the buffer
        do_flush();
        xlat(14'h03D4, 12'h354, 1'b0, 1'b0, "R8 miss after flush");
        xlat(14'h0140, 12'h580, 1'b0, 1'b0, "R8 miss after flush set 1");

        // R12: rewrite an entry, flush, observe new frame
        pt_load(8'h0F, 1'b1, 6'h2D);
        do_flush();
        xlat(14'h03D4, 12'hB54, 1'b0, 1'b0, "R12 rewritten entry");
        xlat(14'h03D4, 12'hB54, 1'b1, 1'b0, "R12 rewritten entry hit");

        repeat (3) @(negedge clk);
        // R10: outputs zero whenever done is low
        checks++;
        if (idle_bad != 0) begin
            failures++;
            $display("FAIL R10: idle cycles with nonzero outputs=%0d expected 0", idle_bad);
        end
        report();
    end
endmodule